// File: doc/BRIEF.md
# Two-Slot Toggle-Flag Clock Crossing Buffer

This block carries a stream of fixed-width tokens from a producer clock domain into a separate consumer clock domain. The consumer clock is unrelated to the producer clock but runs at least as fast. Storage is two payload slots that stay in the producer domain. Each slot has one toggle flag owned by the producer and one owned by the consumer. Each flag reaches the other domain only through a chain of synchronizer flops.

The producer offers a token with a valid/ready handshake. The token is written into the slot at the producer's one-bit head pointer, that slot's producer flag is inverted, and the pointer moves to the other slot. On the other side, the consumer pulses a request. If the synchronized producer flag of its head slot differs from its own flag for that slot, the slot is full. The token is then read, the consumer copies the synchronized value into its own flag, and its pointer advances. If the slot is not full, the consumer returns a fixed filler token, flagged as not valid, and its pointer stays where it is.

Each domain has an enable. While an enable is low, that domain's flags and pointer are held at zero. The two enables are meant to be lowered and raised together, which discards any tokens in flight.

Top module: `tok_cdc_pingpong`

## Requirements
- R1: While the producer reset is active, `prod_ready` is 0. While the consumer reset is active, `cons_out_stb` and `cons_out_valid` are 0. Once reset has been released and `prod_en` is high, `prod_ready` rises within a few producer cycles.
- R2: Every token accepted (`prod_valid` and `prod_ready` both high at a producer clock edge) comes out exactly once, as a valid consumer output, in the order it was accepted. The producer head pointer moves only on an accepted token or while disabled.
- R3: At most two tokens can be accepted and not yet read. With no consumer requests, the producer accepts exactly two tokens and then holds `prod_ready` low. `prod_ready` is always 0 while `prod_en` is 0.
- R4: A request made while the consumer's head slot is empty produces a response with `cons_out_valid` = 0 and `cons_out_data` equal to the parameter `FILL_TOK`.
- R5: `cons_out_stb` is high for exactly one consumer cycle: the cycle after a cycle in which `cons_req` and `cons_en` were both high. It is low at all other times.
- R6: While `cons_en` is low, requests are ignored and no strobe is produced. Lowering both enables discards any tokens in flight, so the first request after both are raised again returns the filler.
- R7: `cons_out_data` and `cons_out_valid` change only in cycles where `cons_out_stb` is high. Between strobes they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prod_clk | input | 1 | Producer domain clock |
| prod_rst_n | input | 1 | Producer asynchronous reset, active low, released synchronously inside |
| prod_en | input | 1 | Producer enable; low clears producer flags and pointer |
| prod_valid | input | 1 | Producer offers a token |
| prod_data | input | TOK_W | Token offered by the producer |
| prod_ready | output | 1 | Head slot is free; the token is taken when this and prod_valid are high |
| cons_clk | input | 1 | Consumer domain clock, at least as fast as prod_clk |
| cons_rst_n | input | 1 | Consumer asynchronous reset, active low, released synchronously inside |
| cons_en | input | 1 | Consumer enable; low clears consumer flags and pointer |
| cons_req | input | 1 | One-cycle request for the next token |
| cons_out_stb | output | 1 | Response strobe, one cycle after a request |
| cons_out_valid | output | 1 | Response holds a real token (0 means filler) |
| cons_out_data | output | TOK_W | Token or filler value |

## Verification
The bench fills both slots while the consumer stays idle. A design that compared the wrong flag pair would either accept a third token and overwrite unread data, or stall after one. It requests a token before anything has been written, so a design that does not test emptiness correctly would return stale payload marked valid instead of the filler. Long random streams run at two non-integer clock ratios and are checked against a queue of accepted tokens, which exposes pointers that fail to alternate, lost tokens and duplicated tokens. The bench also drops both enables while a token is waiting and checks that no strobe appears during the disabled window and that the stale token does not reappear afterwards.

// File: rtl/tcdc_pkg.sv
package tcdc_pkg;
  localparam int unsigned TCDC_SLOTS = 2;

  typedef logic tcdc_ptr_t;

  function automatic tcdc_ptr_t tcdc_adv(input tcdc_ptr_t p);
    return ~p;
  endfunction
endpackage

// File: rtl/tcdc_flag_sync.sv
module tcdc_flag_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= '0;
        else        pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/tcdc_prod.sv
module tcdc_prod
  import tcdc_pkg::*;
#(
  parameter int unsigned TOK_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                en,
  input  logic                                in_valid,
  input  logic [TOK_W-1:0]                    in_data,
  output logic                                in_ready,
  input  logic [TCDC_SLOTS-1:0]               cflag_sync,
  output logic [TCDC_SLOTS-1:0]               pflag,
  output tcdc_ptr_t                           head,
  output logic [TCDC_SLOTS-1:0][TOK_W-1:0]    slot_q
);
  logic [TCDC_SLOTS-1:0] flag_q, flag_d;
  tcdc_ptr_t             ptr_q, ptr_d;
  logic                  slot_free;
  logic                  wr_en;

  // next state
  always_comb begin
    slot_free = (flag_q[ptr_q] == cflag_sync[ptr_q]);
    in_ready  = rst_n & en & slot_free;
    wr_en     = in_ready & in_valid;
    flag_d    = flag_q;
    ptr_d     = ptr_q;
    if (!en) begin
      flag_d = '0;
      ptr_d  = '0;
    end else if (wr_en) begin
      flag_d[ptr_q] = ~flag_q[ptr_q];
      ptr_d         = tcdc_adv(ptr_q);
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ptr_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ptr_q  <= ptr_d;
    end
  end

  // payload registers, written only under an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int s = 0; s < TCDC_SLOTS; s++) begin
        if (wr_en && (ptr_q == 1'(s))) slot_q[s] <= in_data;
      end
    end
  end

  assign pflag = flag_q;
  assign head  = ptr_q;
endmodule

// File: rtl/tcdc_cons.sv
module tcdc_cons
  import tcdc_pkg::*;
#(
  parameter int unsigned      TOK_W    = 8,
  parameter logic [TOK_W-1:0] FILL_TOK = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             req,
  input  logic [TCDC_SLOTS-1:0]            pflag_sync,
  input  logic [TCDC_SLOTS-1:0][TOK_W-1:0] slot_q,
  output logic [TCDC_SLOTS-1:0]            cflag,
  output logic                             out_stb,
  output logic                             out_valid,
  output logic [TOK_W-1:0]                 out_data
);
  logic [TCDC_SLOTS-1:0] flag_q, flag_d;
  tcdc_ptr_t             ptr_q, ptr_d;
  logic                  slot_full;
  logic                  take;
  logic                  stb_d, valid_d;
  logic [TOK_W-1:0]      data_d;

  // next state
  always_comb begin
    slot_full = (pflag_sync[ptr_q] != flag_q[ptr_q]);
    take      = en & req;
    flag_d    = flag_q;
    ptr_d     = ptr_q;
    if (!en) begin
      flag_d = '0;
      ptr_d  = '0;
    end else if (take && slot_full) begin
      flag_d[ptr_q] = pflag_sync[ptr_q];
      ptr_d         = tcdc_adv(ptr_q);
    end
    stb_d   = take;
    valid_d = slot_full;
    data_d  = slot_full ? slot_q[ptr_q] : FILL_TOK;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      ptr_q   <= '0;
      out_stb <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ptr_q   <= ptr_d;
      out_stb <= stb_d;
    end
  end

  // response registers, loaded only when a request is served
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= valid_d;
      out_data  <= data_d;
    end
  end

  assign cflag = flag_q;
endmodule

// File: rtl/tok_cdc_pingpong.sv
module tok_cdc_pingpong
  import tcdc_pkg::*;
#(
  parameter int unsigned      TOK_W       = 8,
  parameter logic [TOK_W-1:0] FILL_TOK    = 8'hE7,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic             prod_clk,
  input  logic             prod_rst_n,
  input  logic             prod_en,
  input  logic             prod_valid,
  input  logic [TOK_W-1:0] prod_data,
  output logic             prod_ready,
  input  logic             cons_clk,
  input  logic             cons_rst_n,
  input  logic             cons_en,
  input  logic             cons_req,
  output logic             cons_out_stb,
  output logic             cons_out_valid,
  output logic [TOK_W-1:0] cons_out_data
);
  logic                             p_rst_sync;
  logic                             c_rst_sync;
  logic [TCDC_SLOTS-1:0]            pflag, pflag_at_c;
  logic [TCDC_SLOTS-1:0]            cflag, cflag_at_p;
  logic [TCDC_SLOTS-1:0][TOK_W-1:0] slots;
  tcdc_ptr_t                        p_head;

  // reset release synchronizers
  tcdc_flag_sync #(.W(1), .STAGES(SYNC_STAGES)) p_rst_i (
    .clk(prod_clk), .rst_n(prod_rst_n), .d(1'b1), .q(p_rst_sync));
  tcdc_flag_sync #(.W(1), .STAGES(SYNC_STAGES)) c_rst_i (
    .clk(cons_clk), .rst_n(cons_rst_n), .d(1'b1), .q(c_rst_sync));

  // flag crossings
  tcdc_flag_sync #(.W(TCDC_SLOTS), .STAGES(SYNC_STAGES)) p2c_i (
    .clk(cons_clk), .rst_n(c_rst_sync), .d(pflag), .q(pflag_at_c));
  tcdc_flag_sync #(.W(TCDC_SLOTS), .STAGES(SYNC_STAGES)) c2p_i (
    .clk(prod_clk), .rst_n(p_rst_sync), .d(cflag), .q(cflag_at_p));

  tcdc_prod #(.TOK_W(TOK_W)) prod_i (
    .clk(prod_clk), .rst_n(p_rst_sync), .en(prod_en),
    .in_valid(prod_valid), .in_data(prod_data), .in_ready(prod_ready),
    .cflag_sync(cflag_at_p), .pflag(pflag), .head(p_head), .slot_q(slots));

  tcdc_cons #(.TOK_W(TOK_W), .FILL_TOK(FILL_TOK)) cons_i (
    .clk(cons_clk), .rst_n(c_rst_sync), .en(cons_en), .req(cons_req),
    .pflag_sync(pflag_at_c), .slot_q(slots), .cflag(cflag),
    .out_stb(cons_out_stb), .out_valid(cons_out_valid), .out_data(cons_out_data));
endmodule

// File: rtl/tcdc_checker.sv
module tcdc_checker #(
  parameter int unsigned      TOK_W    = 8,
  parameter logic [TOK_W-1:0] FILL_TOK = '0
) (
  input logic             p_clk,
  input logic             p_rst_n,
  input logic             prod_en,
  input logic             prod_valid,
  input logic             prod_ready,
  input logic             p_head,
  input logic             c_clk,
  input logic             c_rst_n,
  input logic             cons_en,
  input logic             cons_req,
  input logic             stb,
  input logic             valid,
  input logic [TOK_W-1:0] data
);
  a_r3_no_ready_when_off: assert property (@(posedge p_clk) disable iff (!p_rst_n)
    !prod_en |-> !prod_ready);

  a_r2_head_holds: assert property (@(posedge p_clk) disable iff (!p_rst_n)
    (prod_en && !(prod_valid && prod_ready)) |=> $stable(p_head));

  a_r5_stb_after_req: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    (cons_req && cons_en) |=> stb);

  a_r5_no_stray_stb: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    !(cons_req && cons_en) |=> !stb);

  a_r4_filler_value: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    (stb && !valid) |-> (data == FILL_TOK));

  a_r7_output_hold: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    !stb |-> ($stable(data) && $stable(valid)));
endmodule

bind tok_cdc_pingpong tcdc_checker #(.TOK_W(TOK_W), .FILL_TOK(FILL_TOK)) chk_i (
  .p_clk(prod_clk), .p_rst_n(p_rst_sync), .prod_en(prod_en),
  .prod_valid(prod_valid), .prod_ready(prod_ready), .p_head(p_head),
  .c_clk(cons_clk), .c_rst_n(c_rst_sync), .cons_en(cons_en),
  .cons_req(cons_req), .stb(cons_out_stb), .valid(cons_out_valid),
  .data(cons_out_data));

// File: tb/tok_cdc_pingpong_tb.sv
module tok_cdc_pingpong_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int CONS_PERIOD = 6;
  localparam int TOK_W       = 8;
  localparam logic [TOK_W-1:0] FILL = 8'hE7;

  logic prod_clk = 1'b0, cons_clk = 1'b0;
  logic prod_rst_n, cons_rst_n, prod_en, cons_en;
  logic prod_valid, prod_ready, cons_req;
  logic [TOK_W-1:0] prod_data, cons_out_data;
  logic cons_out_stb, cons_out_valid;

  int prod_half = CLK_PERIOD / 2;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [TOK_W-1:0] exp_q[$];

  always #(prod_half) prod_clk = ~prod_clk;
  always #(CONS_PERIOD / 2) cons_clk = ~cons_clk;

  tok_cdc_pingpong #(.TOK_W(TOK_W), .FILL_TOK(FILL), .SYNC_STAGES(2)) dut_i (
    .prod_clk(prod_clk), .prod_rst_n(prod_rst_n), .prod_en(prod_en),
    .prod_valid(prod_valid), .prod_data(prod_data), .prod_ready(prod_ready),
    .cons_clk(cons_clk), .cons_rst_n(cons_rst_n), .cons_en(cons_en),
    .cons_req(cons_req), .cons_out_stb(cons_out_stb),
    .cons_out_valid(cons_out_valid), .cons_out_data(cons_out_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit hit(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  // producer: offer until n tokens are accepted
  task automatic produce(input int n, input int dens);
    int sent = 0;
    while (sent < n) begin
      @(negedge prod_clk);
      prod_valid = hit(dens);
      prod_data  = TOK_W'($urandom);
      #1;
      if (prod_valid && prod_ready) begin
        exp_q.push_back(prod_data);
        sent++;
      end
      @(posedge prod_clk);
    end
    @(negedge prod_clk);
    prod_valid = 1'b0;
  endtask

  // consumer: request until n real tokens arrive, checking every cycle
  task automatic consume(input int n, input int dens);
    int got = 0;
    bit pend = 1'b0;
    logic [TOK_W-1:0] last_d = cons_out_data;
    logic last_v = cons_out_valid;
    while (got < n || pend) begin
      @(negedge cons_clk);
      if (pend) begin
        check(cons_out_stb == 1'b1, "R5 strobe after request", cons_out_stb, 1);
        if (cons_out_valid) begin
          if (exp_q.size() == 0) check(1'b0, "R2 unexpected token", cons_out_data, 0);
          else begin
            logic [TOK_W-1:0] e = exp_q.pop_front();
            check(cons_out_data == e, "R2 order", cons_out_data, e);
          end
          got++;
        end else begin
          check(cons_out_data == FILL, "R4 filler value", cons_out_data, FILL);
        end
      end else begin
        check(cons_out_stb == 1'b0, "R5 no strobe without request", cons_out_stb, 0);
        check(cons_out_data == last_d && cons_out_valid == last_v,
              "R7 output hold", cons_out_data, last_d);
      end
      last_d = cons_out_data;
      last_v = cons_out_valid;
      cons_req = (got < n) ? hit(dens) : 1'b0;
      pend = cons_req;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    prod_rst_n = 1'b0; cons_rst_n = 1'b0;
    prod_en = 1'b1; cons_en = 1'b1;
    prod_valid = 1'b0; prod_data = '0; cons_req = 1'b0;
    #(CLK_PERIOD * 3 + 2);
    // R1 reset state
    check(prod_ready == 1'b0, "R1 ready in reset", prod_ready, 0);
    check(cons_out_stb == 1'b0 && cons_out_valid == 1'b0, "R1 outputs in reset",
          {cons_out_stb, cons_out_valid}, 0);
    prod_rst_n = 1'b1; cons_rst_n = 1'b1;
    repeat (5) @(negedge prod_clk);
    check(prod_ready == 1'b1, "R1 ready after reset", prod_ready, 1);

    // R4 request while empty gives filler
    @(negedge cons_clk); cons_req = 1'b1;
    @(negedge cons_clk);
    check(cons_out_stb == 1'b1, "R5 strobe", cons_out_stb, 1);
    check(cons_out_valid == 1'b0, "R4 filler not valid", cons_out_valid, 0);
    check(cons_out_data == FILL, "R4 filler data", cons_out_data, FILL);
    cons_req = 1'b0;
    @(negedge cons_clk);
    check(cons_out_stb == 1'b0, "R5 single strobe", cons_out_stb, 0);

    // R3 only two tokens accepted while consumer idle
    begin
      int acc = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge prod_clk);
        prod_valid = 1'b1;
        prod_data  = TOK_W'(8'h10 + i);
        #1;
        if (prod_ready) begin exp_q.push_back(prod_data); acc++; end
      end
      @(negedge prod_clk); prod_valid = 1'b0;
      check(acc == 2, "R3 two-slot limit", acc, 2);
      check(prod_ready == 1'b0, "R3 ready low when full", prod_ready, 0);
    end
    consume(2, 60);
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);

    // R2 random streams at two clock ratios
    fork
      produce(200, 70);
      consume(200, 65);
    join
    check(exp_q.size() == 0, "R2 stream 1 complete", exp_q.size(), 0);
    prod_half = 7;
    repeat (3) @(negedge prod_clk);
    fork
      produce(150, 90);
      consume(150, 40);
    join
    check(exp_q.size() == 0, "R2 stream 2 complete", exp_q.size(), 0);

    // R6 enables: park one token, disable both, check, re-enable
    produce(1, 100);
    repeat (6) @(negedge cons_clk);
    @(negedge prod_clk); prod_en = 1'b0;
    @(negedge cons_clk); cons_en = 1'b0;
    @(negedge prod_clk); #1;
    check(prod_ready == 1'b0, "R6 ready low when disabled", prod_ready, 0);
    @(negedge cons_clk); cons_req = 1'b1;
    @(negedge cons_clk);
    check(cons_out_stb == 1'b0, "R6 request ignored", cons_out_stb, 0);
    cons_req = 1'b0;
    exp_q.delete();
    repeat (4) @(negedge prod_clk);
    prod_en = 1'b1;
    @(negedge cons_clk); cons_en = 1'b1;
    repeat (10) @(negedge cons_clk);
    cons_req = 1'b1;
    @(negedge cons_clk);
    check(cons_out_stb == 1'b1 && cons_out_valid == 1'b0, "R6 stale token dropped",
          {cons_out_stb, cons_out_valid}, 2);
    cons_req = 1'b0;
    fork
      produce(40, 80);
      consume(40, 70);
    join
    check(exp_q.size() == 0, "R2 after re-enable", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule